// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a synchronous DRAM and walks the memory from power-on to a usable state. After reset it keeps the command bus idle for a programmable startup pause, with clock enable and the data mask held high. It then closes every bank with a single precharge-all, runs a batch of auto-refresh commands and loads the mode register. Once the last wait has elapsed it raises a ready flag that stays high.

The mode word is assembled from four configuration inputs: burst length, sequential or interleaved burst addressing, CAS latency, and write mode (burst write or single write). A parameter decides whether the refresh batch runs before or after the mode register load. Activate requests from the rest of the controller are blocked until the sequence is complete.

The sequence is driven by a state machine with these states:
- `ST_PAUSE`: startup pause, left when the pause timer expires.
- `ST_PRECHARGE`: precharge-all, always followed by `ST_WAIT_RP`.
- `ST_WAIT_RP`: left on timer expiry, to `ST_REFRESH` when refresh comes first, otherwise to `ST_MODE_SET`.
- `ST_REFRESH`: an auto-refresh, always followed by `ST_WAIT_RFC`.
- `ST_WAIT_RFC`: left on expiry, back to `ST_REFRESH` while refreshes remain. When the batch is done it goes to `ST_MODE_SET` (refresh first) or to `ST_READY` (refresh last).
- `ST_MODE_SET`: the mode register load, always followed by `ST_WAIT_MRD`.
- `ST_WAIT_MRD`: left on expiry, to `ST_READY` (refresh first) or to `ST_REFRESH` (refresh last).
- `ST_READY`: terminal.

Top module: `sdram_init_seq`

## Requirements
- R1: While rst_n is low, sd_cs_n, sd_ras_n, sd_cas_n and sd_we_n are high, sd_cke is low, sd_dqm is high, and init_done and act_grant are low.
- R2: Counting the first rising edge after reset release as cycle 1, cycles 0 to PAUSE_CYC-1 carry no command (sd_cs_n high). sd_cke is high from cycle 1 onward, and sd_dqm stays high until init_done rises.
- R3: The first command is precharge-all in cycle PAUSE_CYC. It is encoded as sd_cs_n=0, sd_ras_n=0, sd_cas_n=1, sd_we_n=0 with sd_addr[10]=1. The next command follows exactly TRP_CYC cycles later.
- R4: The mode register load is encoded as sd_cs_n, sd_ras_n, sd_cas_n and sd_we_n all 0, with sd_ba zero. sd_addr carries the burst length in [2:0], interleaved addressing (1) in [3], the CAS latency in [6:4] and single write (1) in [9]. All other address bits are 0.
- R5: Exactly NUM_REF auto-refresh commands are issued, each encoded as sd_cs_n=0, sd_ras_n=0, sd_cas_n=0, sd_we_n=1. Each one follows the previous refresh by exactly TRFC_CYC cycles.
- R6: With REF_AFTER_MRS=0 the refresh batch lies between the precharge and the mode register load. With REF_AFTER_MRS=1 the mode register load comes directly after the precharge wait, and the batch follows TMRD_CYC cycles after the load.
- R7: sd_cke is high in the cycle before the mode register load.
- R8: The cycle after the mode register load carries no command.
- R9: init_done rises exactly TRFC_CYC cycles after the last refresh (refresh last) or exactly TMRD_CYC cycles after the mode register load (refresh first), and then stays high.
- R10: act_grant is low while init_done is low, and equals act_req once init_done is high.
- R11: sd_cs_n is low only in command cycles. In every cycle with sd_cs_n high, sd_ras_n, sd_cas_n and sd_we_n are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_burst_len | input | 3 | Burst length code for the mode word |
| cfg_interleave | input | 1 | 1 = interleaved burst addressing |
| cfg_cas_lat | input | 3 | CAS latency code for the mode word |
| cfg_write_single | input | 1 | 1 = burst read with single write |
| act_req | input | 1 | Activate request from the scheduler |
| act_grant | output | 1 | Activate permitted |
| init_done | output | 1 | Sticky ready flag |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_dqm | output | 1 | Data mask |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Address bus |

## Verification
The bench builds two instances with PAUSE_CYC=50, TRP_CYC=3, TRFC_CYC=6, TMRD_CYC=2 and NUM_REF=8, so the whole sequence completes in about a hundred cycles. One instance has REF_AFTER_MRS=0 and the other REF_AFTER_MRS=1, so both refresh placements and every branch out of the wait states are exercised. The two instances use different mode inputs, which toggle every mode field bit between the runs. The short timing values keep every wait a few cycles long, so the exact cycle of each command can be checked against a schedule the bench computes.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [3:0] {
        ST_PAUSE,
        ST_PRECHARGE,
        ST_WAIT_RP,
        ST_REFRESH,
        ST_WAIT_RFC,
        ST_MODE_SET,
        ST_WAIT_MRD,
        ST_READY
    } init_state_e;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PRE_ALL,
        CMD_AUTO_REF,
        CMD_LOAD_MODE
    } sd_cmd_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_pins_t;

    // Bit position of the all-banks flag during precharge
    localparam int A10_POS = 10;

endpackage

// File: rtl/sdram_cmd_pins.sv
module sdram_cmd_pins
    import sdram_init_pkg::*;
(
    input  sd_cmd_e  cmd,
    output sd_pins_t pins
);

    always_comb begin
        pins = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        unique case (cmd)
            CMD_NOP:       pins = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
            CMD_PRE_ALL:   pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            CMD_AUTO_REF:  pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            CMD_LOAD_MODE: pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
            default:       pins = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
    end

endmodule

// File: rtl/sdram_mode_word.sv
module sdram_mode_word #(
    parameter int ADDR_W = 13
) (
    input  logic [2:0]        burst_len,
    input  logic              interleave,
    input  logic [2:0]        cas_lat,
    input  logic              write_single,
    output logic [ADDR_W-1:0] word
);

    // Field positions are decoded by the memory and must stay fixed
    always_comb begin
        word      = '0;
        word[2:0] = burst_len;
        word[3]   = interleave;
        word[6:4] = cas_lat;
        word[9]   = write_single;
    end

endmodule

// File: rtl/sdram_wait_timer.sv
module sdram_wait_timer #(
    parameter int W         = 8,
    parameter int RESET_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= W'(RESET_VAL);
        end else if (load) begin
            count_q <= load_val;
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign expired = (count_q == '0);

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W        = 13,
    parameter int BA_W          = 2,
    parameter int PAUSE_CYC     = 20000,
    parameter int TRP_CYC       = 3,
    parameter int TRFC_CYC      = 8,
    parameter int TMRD_CYC      = 2,
    parameter int NUM_REF       = 8,
    parameter bit REF_AFTER_MRS = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_interleave,
    input  logic [2:0]        cfg_cas_lat,
    input  logic              cfg_write_single,
    input  logic              act_req,
    output logic              act_grant,
    output logic              init_done,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic              sd_dqm,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr
);

    // Every wait must be at least two cycles (command plus one idle)
    localparam int MAX_A  = (PAUSE_CYC > TRP_CYC) ? PAUSE_CYC : TRP_CYC;
    localparam int MAX_B  = (TRFC_CYC > TMRD_CYC) ? TRFC_CYC : TMRD_CYC;
    localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TMR_W  = $clog2(MAX_C + 1);
    localparam int REF_CW = $clog2(NUM_REF + 1);
    localparam logic [REF_CW-1:0] REF_LAST = REF_CW'(NUM_REF);

    init_state_e       state_q, state_d;
    logic [REF_CW-1:0] ref_cnt_q;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_exp;
    logic              cke_q;
    sd_cmd_e           cmd;
    sd_pins_t          pins;
    logic [ADDR_W-1:0] mode_word;

    sdram_wait_timer #(
        .W         (TMR_W),
        .RESET_VAL (PAUSE_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    sdram_mode_word #(
        .ADDR_W (ADDR_W)
    ) u_mode (
        .burst_len    (cfg_burst_len),
        .interleave   (cfg_interleave),
        .cas_lat      (cfg_cas_lat),
        .write_single (cfg_write_single),
        .word         (mode_word)
    );

    sdram_cmd_pins u_pins (
        .cmd  (cmd),
        .pins (pins)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PAUSE;
        end else begin
            state_q <= state_d;
        end
    end

    // Refresh counter and clock-enable register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_cnt_q <= '0;
            cke_q     <= 1'b0;
        end else begin
            cke_q <= 1'b1;
            if (state_q == ST_REFRESH) begin
                ref_cnt_q <= ref_cnt_q + 1'b1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PAUSE:     if (tmr_exp) state_d = ST_PRECHARGE;
            ST_PRECHARGE: state_d = ST_WAIT_RP;
            ST_WAIT_RP: begin
                if (tmr_exp) state_d = REF_AFTER_MRS ? ST_MODE_SET : ST_REFRESH;
            end
            ST_REFRESH:   state_d = ST_WAIT_RFC;
            ST_WAIT_RFC: begin
                if (tmr_exp) begin
                    if (ref_cnt_q != REF_LAST) begin
                        state_d = ST_REFRESH;
                    end else begin
                        state_d = REF_AFTER_MRS ? ST_READY : ST_MODE_SET;
                    end
                end
            end
            ST_MODE_SET:  state_d = ST_WAIT_MRD;
            ST_WAIT_MRD: begin
                if (tmr_exp) state_d = REF_AFTER_MRS ? ST_REFRESH : ST_READY;
            end
            ST_READY:     state_d = ST_READY;
            default:      state_d = ST_PAUSE;
        endcase
    end

    // Output logic
    always_comb begin
        cmd       = CMD_NOP;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        sd_addr   = '0;
        sd_ba     = '0;
        init_done = 1'b0;
        unique case (state_q)
            ST_PRECHARGE: begin
                cmd              = CMD_PRE_ALL;
                sd_addr[A10_POS] = 1'b1;
                tmr_load         = 1'b1;
                tmr_val          = TMR_W'(TRP_CYC - 2);
            end
            ST_REFRESH: begin
                cmd      = CMD_AUTO_REF;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(TRFC_CYC - 2);
            end
            ST_MODE_SET: begin
                cmd      = CMD_LOAD_MODE;
                sd_addr  = mode_word;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(TMRD_CYC - 2);
            end
            ST_READY: init_done = 1'b1;
            ST_PAUSE, ST_WAIT_RP, ST_WAIT_RFC, ST_WAIT_MRD: cmd = CMD_NOP;
            default: cmd = CMD_NOP;
        endcase
    end

    assign sd_cs_n   = pins.cs_n;
    assign sd_ras_n  = pins.ras_n;
    assign sd_cas_n  = pins.cas_n;
    assign sd_we_n   = pins.we_n;
    assign sd_cke    = cke_q;
    assign sd_dqm    = ~init_done;
    assign act_grant = act_req & init_done;

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              act_req,
    input logic              act_grant,
    input logic              init_done,
    input logic              sd_cke,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic              sd_dqm,
    input logic [ADDR_W-1:0] sd_addr
);

    logic is_mrs, is_pre, is_idle;
    assign is_mrs  = !sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n;
    assign is_pre  = !sd_cs_n && !sd_ras_n && sd_cas_n && !sd_we_n;
    assign is_idle = sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n;

    // R7
    cke_before_mrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> $past(sd_cke));

    // R8
    nop_after_mrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |=> is_idle);

    // R3
    pre_all_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> sd_addr[10]);

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R10
    grant_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_grant |-> (init_done && act_req));

    // R11
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cs_n |-> is_idle);

    // R2
    dqm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> sd_dqm);

endmodule

bind sdram_init_seq sdram_init_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .act_req   (act_req),
    .act_grant (act_grant),
    .init_done (init_done),
    .sd_cke    (sd_cke),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_dqm    (sd_dqm),
    .sd_addr   (sd_addr)
);

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;

    localparam int AW    = 13;
    localparam int BW    = 2;
    localparam int P     = 50;
    localparam int TRP   = 3;
    localparam int TRFC  = 6;
    localparam int TMRD  = 2;
    localparam int NREF  = 8;
    localparam int MAXEV = 16;

    // Command codes used by the bench monitor
    localparam int C_NOP = 0, C_PRE = 1, C_REF = 2, C_MRS = 3, C_BAD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic act_req = 1'b1;
    always #5 clk = ~clk;

    logic [2:0]    bl  [2];
    logic          il  [2];
    logic [2:0]    cl  [2];
    logic          ws  [2];
    logic          grant [2], done [2], cke [2], cs_n [2], ras_n [2], cas_n [2], we_n [2], dqm [2];
    logic [BW-1:0] ba  [2];
    logic [AW-1:0] addr [2];

    initial begin
        bl[0] = 3'b011; il[0] = 1'b0; cl[0] = 3'b010; ws[0] = 1'b0;
        bl[1] = 3'b100; il[1] = 1'b1; cl[1] = 3'b101; ws[1] = 1'b1;
    end

    sdram_init_seq #(.ADDR_W(AW), .BA_W(BW), .PAUSE_CYC(P), .TRP_CYC(TRP), .TRFC_CYC(TRFC),
                     .TMRD_CYC(TMRD), .NUM_REF(NREF), .REF_AFTER_MRS(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_burst_len(bl[0]), .cfg_interleave(il[0]),
        .cfg_cas_lat(cl[0]), .cfg_write_single(ws[0]), .act_req(act_req),
        .act_grant(grant[0]), .init_done(done[0]), .sd_cke(cke[0]), .sd_cs_n(cs_n[0]),
        .sd_ras_n(ras_n[0]), .sd_cas_n(cas_n[0]), .sd_we_n(we_n[0]), .sd_dqm(dqm[0]),
        .sd_ba(ba[0]), .sd_addr(addr[0]));

    sdram_init_seq #(.ADDR_W(AW), .BA_W(BW), .PAUSE_CYC(P), .TRP_CYC(TRP), .TRFC_CYC(TRFC),
                     .TMRD_CYC(TMRD), .NUM_REF(NREF), .REF_AFTER_MRS(1'b1)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .cfg_burst_len(bl[1]), .cfg_interleave(il[1]),
        .cfg_cas_lat(cl[1]), .cfg_write_single(ws[1]), .act_req(act_req),
        .act_grant(grant[1]), .init_done(done[1]), .sd_cke(cke[1]), .sd_cs_n(cs_n[1]),
        .sd_ras_n(ras_n[1]), .sd_cas_n(cas_n[1]), .sd_we_n(we_n[1]), .sd_dqm(dqm[1]),
        .sd_ba(ba[1]), .sd_addr(addr[1]));

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int            ev_cnt  [2];
    int            ev_cyc  [2][MAXEV];
    int            ev_cmd  [2][MAXEV];
    logic [AW-1:0] ev_addr [2][MAXEV];
    logic [BW-1:0] ev_ba   [2][MAXEV];
    int            done_cyc [2];
    int v_pause [2], v_cke [2], v_dqm [2], v_cs [2], v_grant [2], v_drop [2], v_after [2];
    logic          prev_mrs [2];

    task automatic check(input string req, input int actual, input int expected, input string what);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
        end
    endtask

    function automatic int decode(input int d);
        if (cs_n[d]) return C_NOP;
        case ({ras_n[d], cas_n[d], we_n[d]})
            3'b010:  return C_PRE;
            3'b001:  return C_REF;
            3'b000:  return C_MRS;
            default: return C_BAD;
        endcase
    endfunction

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    initial begin
        for (int d = 0; d < 2; d++) begin
            ev_cnt[d] = 0; done_cyc[d] = -1; prev_mrs[d] = 1'b0;
            v_pause[d] = 0; v_cke[d] = 0; v_dqm[d] = 0; v_cs[d] = 0;
            v_grant[d] = 0; v_drop[d] = 0; v_after[d] = 0;
        end
    end

    // Cycle monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            for (int d = 0; d < 2; d++) begin
                int c;
                c = decode(d);
                if (cyc < P && c != C_NOP) v_pause[d]++;
                if (cyc >= 1 && !cke[d]) v_cke[d]++;
                if (!done[d] && !dqm[d]) v_dqm[d]++;
                if (c == C_BAD || (cs_n[d] && !(ras_n[d] && cas_n[d] && we_n[d]))) v_cs[d]++;
                if (grant[d] && !done[d]) v_grant[d]++;
                if (done_cyc[d] >= 0 && !done[d]) v_drop[d]++;
                if (prev_mrs[d] && c != C_NOP) v_after[d]++;
                prev_mrs[d] = (c == C_MRS);
                if (done[d] && done_cyc[d] < 0) done_cyc[d] = cyc;
                if (c != C_NOP && ev_cnt[d] < MAXEV) begin
                    ev_cyc[d][ev_cnt[d]]  = cyc;
                    ev_cmd[d][ev_cnt[d]]  = c;
                    ev_addr[d][ev_cnt[d]] = addr[d];
                    ev_ba[d][ev_cnt[d]]   = ba[d];
                    ev_cnt[d]++;
                end
            end
        end
    end

    function automatic logic [AW-1:0] exp_mode(input int d);
        logic [AW-1:0] w;
        w = '0;
        w[2:0] = bl[d]; w[3] = il[d]; w[6:4] = cl[d]; w[9] = ws[d];
        return w;
    endfunction

    // Reset state
    task automatic t_reset();
        for (int d = 0; d < 2; d++) begin
            check("R1", int'({cs_n[d], ras_n[d], cas_n[d], we_n[d]}), 15, "command pins in reset");
            check("R1", int'(cke[d]), 0, "cke in reset");
            check("R1", int'(dqm[d]), 1, "dqm in reset");
            check("R1", int'({done[d], grant[d]}), 0, "done/grant in reset");
        end
    endtask

    // Pause, clock enable, data mask and chip select hygiene
    task automatic t_pause_and_pins();
        for (int d = 0; d < 2; d++) begin
            check("R2", v_pause[d], 0, "commands during pause");
            check("R2", v_cke[d], 0, "cke low cycles after reset");
            check("R2", v_dqm[d], 0, "dqm low before ready");
            check("R11", v_cs[d], 0, "illegal pin combinations");
            check("R8", v_after[d], 0, "command right after mode set");
        end
    endtask

    // Full schedule against the computed expectation
    task automatic t_schedule(input int d, input bit ref_last);
        int e_cyc [MAXEV];
        int e_cmd [MAXEV];
        int n, t, mrs_i, last_cmd;
        n = 0;
        e_cyc[n] = P; e_cmd[n] = C_PRE; n++;
        t = P + TRP;
        if (!ref_last) begin
            for (int k = 0; k < NREF; k++) begin e_cyc[n] = t; e_cmd[n] = C_REF; n++; t += TRFC; end
            mrs_i = n; e_cyc[n] = t; e_cmd[n] = C_MRS; n++; t += TMRD;
        end else begin
            mrs_i = n; e_cyc[n] = t; e_cmd[n] = C_MRS; n++; t += TMRD;
            for (int k = 0; k < NREF; k++) begin e_cyc[n] = t; e_cmd[n] = C_REF; n++; t += TRFC; end
        end
        check("R5", ev_cnt[d], n, "command count (NUM_REF refreshes plus two)");
        for (int i = 0; i < n && i < ev_cnt[d]; i++) begin
            case (e_cmd[i])
                C_PRE:   begin
                    check("R3", ev_cmd[d][i], e_cmd[i], "precharge-all code");
                    check("R3", ev_cyc[d][i], e_cyc[i], "precharge cycle");
                    check("R3", int'(ev_addr[d][i][10]), 1, "precharge A10");
                end
                C_REF:   begin
                    check("R5", ev_cmd[d][i], e_cmd[i], "refresh code");
                    check("R5", ev_cyc[d][i], e_cyc[i], "refresh cycle");
                end
                default: begin
                    check("R6", ev_cmd[d][i], e_cmd[i], "mode set position");
                    check("R6", ev_cyc[d][i], e_cyc[i], "mode set cycle");
                    check("R4", int'(ev_addr[d][i]), int'(exp_mode(d)), "mode word");
                    check("R4", int'(ev_ba[d][i]), 0, "bank address at mode set");
                end
            endcase
        end
        last_cmd = ref_last ? e_cyc[n-1] + TRFC : e_cyc[mrs_i] + TMRD;
        check("R9", done_cyc[d], last_cmd, "init_done rise cycle");
        check("R7", v_cke[d], 0, "cke high before mode set");
    endtask

    // Activate gating and sticky ready
    task automatic t_grant();
        for (int d = 0; d < 2; d++) check("R10", v_grant[d], 0, "grant before ready");
        @(negedge clk); act_req = 1'b0;
        @(negedge clk);
        for (int d = 0; d < 2; d++) check("R10", int'(grant[d]), 0, "grant with no request");
        act_req = 1'b1;
        @(negedge clk);
        for (int d = 0; d < 2; d++) check("R10", int'(grant[d]), 1, "grant follows request");
        repeat (20) @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            check("R9", int'(done[d]), 1, "init_done held");
            check("R9", v_drop[d], 0, "init_done dropped");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        while ((done_cyc[0] < 0 || done_cyc[1] < 0) && cyc < 3000) @(negedge clk);
        if (done_cyc[0] < 0 || done_cyc[1] < 0) begin
            checks++; errors++;
            $display("FAIL R9 watchdog: actual=%0d expected<%0d", cyc, 3000);
        end else begin
            t_pause_and_pins();
            t_schedule(0, 1'b0);
            t_schedule(1, 1'b1);
            t_grant();
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule